// File: doc/BRIEF.md
# Partial Reconfiguration Loader

This block receives configuration words from a shared DMA stream, keeps only the words whose core-select tag names the reconfiguration engine, and loads them in chunks into a configuration write port. A chunk is staged in a 15-entry intermediate buffer. No word goes to the port until the buffer is full. Each word is then bit-swapped and written out one per cycle, with a pause for as long as the port reports busy.

Progress goes back to the host as a one-cycle interrupt pulse with a 4-bit code:

- Code 15: the buffer has filled.
- Code 13: an intermediate chunk has drained.
- Code 12: the final chunk has drained.

The host says whether a chunk is the final one through a flag. The block samples that flag when the chunk starts.

From the first word of a reconfiguration until the end of the region reset, the block holds a lock that other cores use to stop their DMA traffic. After the final chunk it holds a reset to the reloaded region for a fixed number of cycles. It then releases the lock and goes back to idle.

Top module: `pr_loader`

## Requirements
- R1: After reset, dma_ready_o, cfg_ce_o, cfg_we_o, irq_o, dma_lock_o and region_rst_o are low, and irq_code_o is 0.
- R2: A DMA word is taken only in a cycle where dma_valid_i is high, dma_sel_i equals CORE_SEL (default 2) and dma_ready_o is high. In idle, dma_ready_o is low and words with any other select value change nothing. In the fill phase, such words are dropped from the loaded data.
- R3: A select-matching valid word seen in idle starts a reconfiguration. dma_lock_o is high from the next cycle on.
- R4: No configuration write happens before 15 words have been taken. The cycle after the 15th word is taken, irq_o pulses with irq_code_o = 15.
- R5: A gap in DMA data during filling suspends the fill. Filling resumes when data reappears, and no words are lost or reordered.
- R6: Each written word has the bit order reversed inside each byte, with byte positions kept. For example, 0x01234567 is written as 0x80C4A2E6.
- R7: cfg_ce_o and cfg_we_o are high together for exactly one cycle per word. The 15 words go out in arrival order.
- R8: A write is issued only after a clock edge at which cfg_busy_i was low. While cfg_busy_i stays high, no words go out.
- R9: The cycle after the last staged word is written, irq_o pulses once. The code is 13 for an intermediate chunk or 12 for the final chunk.
- R10: dma_lock_o stays high across all chunks of one reconfiguration, including the fill gaps and the time between chunks. dma_ready_o is low while words are being written.
- R11: region_rst_o rises in the cycle of the code-12 interrupt and stays high for 16 cycles. dma_lock_o then falls, and the block accepts a new reconfiguration.
- R12: last_chunk_i is sampled on leaving idle and on the code-13 interrupt edge. Later changes during that chunk have no effect on its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_valid_i | input | 1 | DMA word present |
| dma_sel_i | input | SEL_W | Core select tag of the DMA word |
| dma_data_i | input | DATA_W | DMA word |
| dma_ready_o | output | 1 | Loader can take a word this cycle |
| last_chunk_i | input | 1 | Host flag: the chunk is the final one |
| cfg_busy_i | input | 1 | Configuration port busy, hold writes |
| cfg_ce_o | output | 1 | Configuration port enable |
| cfg_we_o | output | 1 | Configuration port write strobe |
| cfg_data_o | output | DATA_W | Bit-swapped configuration word |
| irq_o | output | 1 | Interrupt pulse |
| irq_code_o | output | 4 | Interrupt code: 15, 13 or 12 |
| dma_lock_o | output | 1 | Lock that freezes other DMA traffic |
| region_rst_o | output | 1 | Reset to the reloaded region |

## Verification
The assertions assume that cfg_busy_i and the DMA inputs change only between clock edges. They also assume that the host keeps supplying select-matching words until each chunk reaches 15, so a chunk is never left part-filled at the end of a test.

The bench drives every input on the falling edge and holds each DMA word until dma_ready_o has been seen high across a rising edge. Busy is raised only during the write phase, and every chunk is completed with all 15 words. Foreign-select words are placed only in idle and inside a fill gap, where the requirements say exactly what must happen to them.

// File: rtl/pr_loader_pkg.sv
package pr_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_SEND,
    ST_RESET
  } ld_state_e;

  localparam logic [3:0] IRQ_FULL  = 4'd15;
  localparam logic [3:0] IRQ_CHUNK = 4'd13;
  localparam logic [3:0] IRQ_DONE  = 4'd12;
endpackage

// File: rtl/pr_stage_fifo.sv
module pr_stage_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 15,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              empty_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CNT_MAX)); // R4
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0)); // R7
endmodule

// File: rtl/pr_bit_swap.sv
module pr_bit_swap #(
  parameter int DATA_W = 32,
  localparam int N_BYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] d_o
);
  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign d_o[b*8 + k] = d_i[b*8 + 7 - k];
    end
  end
endmodule

// File: rtl/pr_loader_fsm.sv
module pr_loader_fsm
  import pr_loader_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int CORE_SEL    = 2,
  parameter int CHUNK_WORDS = 15,
  parameter int RST_CYCLES  = 16,
  localparam int CNT_W = $clog2(CHUNK_WORDS + 1),
  localparam int RC_W  = $clog2(RST_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_valid_i,
  input  logic [SEL_W-1:0] dma_sel_i,
  output logic             dma_ready_o,
  input  logic             last_chunk_i,
  input  logic             cfg_busy_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             fifo_empty_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             cfg_wr_o,
  output logic             irq_o,
  output logic [3:0]       irq_code_o,
  output logic             lock_o,
  output logic             region_rst_o
);
  localparam logic [SEL_W-1:0] SEL_ME   = SEL_W'(CORE_SEL);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CHUNK_WORDS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHUNK_WORDS - 1);
  localparam logic [RC_W-1:0]  RC_LAST  = RC_W'(RST_CYCLES - 1);

  ld_state_e       state_q;
  logic            last_q, lock_q, rrst_q, irq_q, wr_q;
  logic [3:0]      code_q;
  logic [RC_W-1:0] rc_q;
  logic            sel_hit, accept;

  assign sel_hit     = dma_valid_i && (dma_sel_i == SEL_ME);
  assign dma_ready_o = ((state_q == ST_FILL) || (state_q == ST_WAIT)) && (fifo_cnt_i < CNT_FULL);
  assign accept      = sel_hit && dma_ready_o;
  assign push_o      = accept;
  assign pop_o       = (state_q == ST_SEND) && !cfg_busy_i && !fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
      lock_q  <= 1'b0;
      rrst_q  <= 1'b0;
      irq_q   <= 1'b0;
      wr_q    <= 1'b0;
      code_q  <= '0;
      rc_q    <= '0;
    end else begin
      irq_q <= 1'b0;
      wr_q  <= pop_o;
      unique case (state_q)
        ST_IDLE: if (sel_hit) begin
          state_q <= ST_FILL;
          lock_q  <= 1'b1;
          last_q  <= last_chunk_i;
        end
        ST_FILL, ST_WAIT: begin
          if (accept) begin
            if (fifo_cnt_i == CNT_LAST) begin
              state_q <= ST_SEND;
              irq_q   <= 1'b1;
              code_q  <= IRQ_FULL;
            end else begin
              state_q <= ST_FILL;
            end
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_SEND: if (fifo_empty_i) begin
          irq_q <= 1'b1;
          if (last_q) begin
            code_q  <= IRQ_DONE;
            state_q <= ST_RESET;
            rrst_q  <= 1'b1;
            rc_q    <= '0;
          end else begin
            code_q  <= IRQ_CHUNK;
            state_q <= ST_FILL;
            last_q  <= last_chunk_i;
          end
        end
        ST_RESET: begin
          if (rc_q == RC_LAST) begin
            rrst_q  <= 1'b0;
            lock_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            rc_q <= rc_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_wr_o     = wr_q;
  assign irq_o        = irq_q;
  assign irq_code_o   = code_q;
  assign lock_o       = lock_q;
  assign region_rst_o = rrst_q;

  AST_NO_WRITE_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> !$past(cfg_busy_i)); // R8
  AST_WRITE_UNDER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> lock_q); // R10
  AST_RESET_UNDER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rrst_q |-> lock_q); // R11
  AST_IRQ_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (code_q == IRQ_FULL || code_q == IRQ_CHUNK || code_q == IRQ_DONE)); // R9
  AST_FULL_BEFORE_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND && $past(state_q) != ST_SEND) |-> (fifo_cnt_i == CNT_FULL)); // R4
endmodule

// File: rtl/pr_loader.sv
module pr_loader #(
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 3,
  parameter int CORE_SEL    = 2,
  parameter int CHUNK_WORDS = 15,
  parameter int RST_CYCLES  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_valid_i,
  input  logic [SEL_W-1:0]  dma_sel_i,
  input  logic [DATA_W-1:0] dma_data_i,
  output logic              dma_ready_o,
  input  logic              last_chunk_i,
  input  logic              cfg_busy_i,
  output logic              cfg_ce_o,
  output logic              cfg_we_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              irq_o,
  output logic [3:0]        irq_code_o,
  output logic              dma_lock_o,
  output logic              region_rst_o
);
  localparam int CNT_W = $clog2(CHUNK_WORDS + 1);

  logic              push, pop, fifo_empty, cfg_wr;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [DATA_W-1:0] head, head_swapped, cfg_data_q;

  pr_stage_fifo #(.DATA_W(DATA_W), .DEPTH(CHUNK_WORDS)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (dma_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .cnt_o       (fifo_cnt),
    .empty_o     (fifo_empty)
  );

  pr_bit_swap #(.DATA_W(DATA_W)) u_swap (
    .d_i (head),
    .d_o (head_swapped)
  );

  pr_loader_fsm #(
    .SEL_W       (SEL_W),
    .CORE_SEL    (CORE_SEL),
    .CHUNK_WORDS (CHUNK_WORDS),
    .RST_CYCLES  (RST_CYCLES)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dma_valid_i  (dma_valid_i),
    .dma_sel_i    (dma_sel_i),
    .dma_ready_o  (dma_ready_o),
    .last_chunk_i (last_chunk_i),
    .cfg_busy_i   (cfg_busy_i),
    .fifo_cnt_i   (fifo_cnt),
    .fifo_empty_i (fifo_empty),
    .push_o       (push),
    .pop_o        (pop),
    .cfg_wr_o     (cfg_wr),
    .irq_o        (irq_o),
    .irq_code_o   (irq_code_o),
    .lock_o       (dma_lock_o),
    .region_rst_o (region_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cfg_data_q <= '0;
    else if (pop) cfg_data_q <= head_swapped;
  end

  assign cfg_ce_o   = cfg_wr;
  assign cfg_we_o   = cfg_wr;
  assign cfg_data_o = cfg_data_q;

  AST_NO_INTAKE_WHILE_WRITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |-> !dma_ready_o || !$past(fifo_empty)); // R10
endmodule

// File: tb/pr_loader_bench.sv
`timescale 1ns/1ps
module pr_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_valid = 1'b0;
  logic [2:0]  dma_sel = '0;
  logic [31:0] dma_data = '0;
  logic        dma_ready, last_chunk = 1'b0, cfg_busy = 1'b0;
  logic        cfg_ce, cfg_we, irq, dma_lock, region_rst;
  logic [31:0] cfg_data;
  logic [3:0]  irq_code;

  always #2 clk = ~clk;

  pr_loader u_pr_loader (
    .clk_i(clk), .rst_ni(rst_n), .dma_valid_i(dma_valid), .dma_sel_i(dma_sel),
    .dma_data_i(dma_data), .dma_ready_o(dma_ready), .last_chunk_i(last_chunk),
    .cfg_busy_i(cfg_busy), .cfg_ce_o(cfg_ce), .cfg_we_o(cfg_we), .cfg_data_o(cfg_data),
    .irq_o(irq), .irq_code_o(irq_code), .dma_lock_o(dma_lock), .region_rst_o(region_rst)
  );

  int n_chk = 0, n_bad = 0;
  int wr_n = 0, rst_hi = 0;
  logic [31:0] wr_log [0:127];
  logic busy_at_edge = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] swap_exp(input logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++) r[b*8+k] = w[b*8+7-k];
    return r;
  endfunction

  function automatic logic [31:0] word_of(input int chunk, input int i);
    return 32'h01234567 + chunk * 32'h0F00_0000 + i * 32'h1020_3041;
  endfunction

  always @(posedge clk) busy_at_edge <= cfg_busy;

  always @(negedge clk) if (rst_n) begin
    if (cfg_ce || cfg_we) begin
      check(cfg_ce == cfg_we, "R7 ce/we together", {31'd0, cfg_we}, {31'd0, cfg_ce});
      check(!busy_at_edge, "R8 write after busy edge", {31'd0, busy_at_edge}, 32'd0);
      if (wr_n < 128) wr_log[wr_n] = cfg_data;
      wr_n++;
    end
    if (region_rst) begin
      rst_hi++;
      check(dma_lock, "R11 lock during region reset", {31'd0, dma_lock}, 32'd1);
    end
    if (irq && irq_code == 4'd12)
      check(region_rst, "R11 reset rises with code 12", {31'd0, region_rst}, 32'd1);
  end

  task automatic dma_word(input logic [31:0] d);
    dma_valid = 1'b1; dma_sel = 3'd2; dma_data = d;
    while (!dma_ready) @(negedge clk);
    @(negedge clk);
    dma_valid = 1'b0;
  endtask

  task automatic wait_irq(output logic [3:0] code);
    code = 4'hx;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (irq) begin code = irq_code; return; end
    end
    check(1'b0, "R9 interrupt timeout", 32'd0, 32'd1);
  endtask

  task automatic check_writes(input int base, input int chunk, input string req);
    check(wr_n == base + 15, req, wr_n - base, 15);
    for (int i = 0; i < 15; i++)
      check(wr_log[base+i] == swap_exp(word_of(chunk, i)), req, wr_log[base+i], swap_exp(word_of(chunk, i)));
  endtask

  task automatic t_reset;
    check({dma_ready, cfg_ce, cfg_we, irq, dma_lock, region_rst} == 6'b0, "R1 outputs low",
          {26'd0, dma_ready, cfg_ce, cfg_we, irq, dma_lock, region_rst}, 32'd0);
    check(irq_code == 4'd0, "R1 irq code", {28'd0, irq_code}, 32'd0);
  endtask

  task automatic t_foreign_idle;
    dma_valid = 1'b1; dma_sel = 3'd1; dma_data = 32'hDEADBEEF;
    repeat (5) @(negedge clk);
    check(!dma_lock && !dma_ready, "R2 foreign select in idle", {30'd0, dma_lock, dma_ready}, 32'd0);
    dma_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_chunk_gap_busy;
    logic [3:0] c;
    last_chunk = 1'b0;
    for (int i = 0; i < 7; i++) begin
      dma_word(word_of(0, i));
      if (i == 0) check(dma_lock, "R3 lock after start", {31'd0, dma_lock}, 32'd1);
    end
    dma_valid = 1'b1; dma_sel = 3'd1; dma_data = 32'hDEADBEEF;
    repeat (4) @(negedge clk);
    dma_valid = 1'b0;
    check(dma_lock && dma_ready, "R10 lock and ready in gap", {30'd0, dma_lock, dma_ready}, 32'd3);
    for (int i = 7; i < 15; i++) dma_word(word_of(0, i));
    check(irq && irq_code == 4'd15, "R4 full interrupt", {27'd0, irq, irq_code}, {27'd0, 1'b1, 4'd15});
    check(wr_n == 0, "R4 no write before full", wr_n, 0);
    last_chunk = 1'b1;
    cfg_busy = 1'b1;
    repeat (6) @(negedge clk);
    check(wr_n == 0, "R8 held while busy", wr_n, 0);
    check(!dma_ready, "R10 ready low while sending", {31'd0, dma_ready}, 32'd0);
    cfg_busy = 1'b0;
    wait_irq(c);
    check(c == 4'd13, "R9 intermediate code", {28'd0, c}, 32'd13);
    check(wr_log[0] == 32'h80C4A2E6, "R6 swap literal", wr_log[0], 32'h80C4A2E6);
    check_writes(0, 0, "R5 R6 R7 R2 chunk data");
    check(dma_lock && !region_rst, "R10 lock between chunks", {30'd0, dma_lock, region_rst}, 32'd2);
  endtask

  task automatic t_final_chunk;
    logic [3:0] c;
    int base, rst0;
    base = wr_n; rst0 = rst_hi;
    for (int i = 0; i < 15; i++) begin
      dma_word(word_of(1, i));
      if (i == 2) last_chunk = 1'b0;
    end
    check(irq && irq_code == 4'd15, "R4 full interrupt chunk 2", {27'd0, irq, irq_code}, {27'd0, 1'b1, 4'd15});
    wait_irq(c);
    check(c == 4'd12, "R12 final code from start sample", {28'd0, c}, 32'd12);
    check_writes(base, 1, "R7 chunk 2 data");
    repeat (20) @(negedge clk);
    check(rst_hi - rst0 == 16, "R11 region reset length", rst_hi - rst0, 16);
    check(!dma_lock && !dma_ready, "R11 lock released, idle", {30'd0, dma_lock, dma_ready}, 32'd0);
  endtask

  task automatic t_new_reconfig;
    logic [3:0] c;
    int base;
    last_chunk = 1'b0;
    base = wr_n;
    for (int i = 0; i < 15; i++) begin
      dma_word(word_of(2, i));
      if (i == 4) last_chunk = 1'b1;
    end
    wait_irq(c);
    check(c == 4'd13, "R12 late raise ignored", {28'd0, c}, 32'd13);
    check_writes(base, 2, "R11 new reconfiguration data");
    for (int i = 0; i < 15; i++) dma_word(word_of(3, i));
    wait_irq(c);
    check(c == 4'd12, "R9 final code", {28'd0, c}, 32'd12);
    repeat (20) @(negedge clk);
    check(rst_hi == 32, "R11 second region reset", rst_hi, 32);
    check(!dma_lock, "R11 lock released", {31'd0, dma_lock}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_foreign_idle;
    t_chunk_gap_busy;
    t_final_chunk;
    t_new_reconfig;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #80000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule